// File: doc/BRIEF.md
# Arithmetic Condition Code Generator

This block turns an operation selector and up to three operands into a 2-bit condition code. The operands are a first operand, a second operand and the result of an operation that has already been carried out elsewhere. The block never does the arithmetic itself. It classifies the operands and the result that it is given.

It covers the following operation families:
- signed and unsigned compares
- a signed test of the result against zero
- signed add and subtract with overflow detection
- logical add and logical subtract, each with and without a carry or borrow input
- absolute value, negative absolute value and complement
- a plain nonzero test
- four selectors that pass a fixed code straight through

A width select picks a 64-bit or a 32-bit reading of every operand. Carry-in and borrow-in are not separate inputs. The block infers them from the operands and the result.

The code appears on a registered output one clock after the inputs are presented. A selector outside the defined set gives code 0 and raises an illegal-operation flag in the same cycle as the code.

Top module: `cc_gen`

## Requirements
- R1: A synchronous active-high reset clears `cc_o` to 0 and `illegal_o` to 0. Outside reset, both outputs reflect the inputs sampled at the previous rising clock edge.
- R2: Selectors 0, 1, 2 and 3 give a code equal to the selector value, whatever the operands are.
- R3: Selector 4 is a signed compare and selector 5 is an unsigned compare, both of `opa_i` against `opb_i`. The code is 0 when they are equal, 1 when `opa_i` is lower and 2 when it is higher.
- R4: Selector 6 tests `res_i` as a signed value against zero. The code is 0 for zero, 1 for negative and 2 for positive.
- R5: Selector 8 is signed add. The code is 3 when both operands are strictly positive and the result is negative, or when both operands are negative and the result is strictly positive. Otherwise the code is 1 for a negative result, 2 for a positive result and 0 for zero.
- R6: Selector 9 is signed subtract. The code is 3 when the first operand is strictly positive, the second is negative and the result is negative. It is also 3 when the first is negative, the second is strictly positive and the result is strictly positive. Otherwise the code follows the sign of the result as in R5.
- R7: Selectors 10 and 11 are logical add, selector 11 with an implied carry-in. Bit 0 of the code is set when the result is nonzero and bit 1 when there is a carry-out. For selector 10, carry-out means result < first operand, compared unsigned. For selector 11, it also counts when (result − first operand) is unsigned-below the second operand.
- R8: Selector 12 is logical subtract without borrow. The code is 2 for a zero result. For a nonzero result it is 1 when the second operand is unsigned-greater than the first, and 3 otherwise.
- R9: Selector 13 is logical subtract with an inferred borrow-in. A borrow-in is assumed when the result differs from (first − second), taken modulo the operand width. Borrow-out is (second ≥ first) when a borrow-in is assumed and (second > first) otherwise. Bit 0 of the code is set for a nonzero result and bit 1 when there is no borrow-out.
- R10: Selector 14 (absolute value) and selector 16 (complement) give code 3 when the result equals the most negative value. Otherwise selector 14 gives 1 for nonzero and 0 for zero, and selector 16 gives 1 for negative, 2 for positive and 0 for zero.
- R11: Selector 15 (negative absolute value) and selector 7 (nonzero test) give 1 when `res_i` is nonzero and 0 otherwise.
- R12: With `wide_i` = 0, only bits 31:0 of each operand count and bit 31 is the sign. The upper bits have no effect on the code. With `wide_i` = 1, all 64 bits count and bit 63 is the sign.
- R13: Any selector from 17 to 31 gives code 0 and sets `illegal_o` to 1. Every defined selector gives `illegal_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| op_i | input | 5 | Operation selector |
| wide_i | input | 1 | 1 selects the 64-bit reading, 0 selects the 32-bit reading |
| opa_i | input | 64 | First operand |
| opb_i | input | 64 | Second operand |
| res_i | input | 64 | Result of the operation being classified |
| cc_o | output | 2 | Registered condition code |
| illegal_o | output | 1 | Registered flag for an undefined selector |

## Verification
The bench builds the block with its default parameters: a 64-bit operand width and a 32-bit narrow width. Both interpretations can therefore be driven through `wide_i` within one build.

The narrow vectors put nonzero values in bits 63:32 so that any use of the upper bits changes the code. They also put sign and carry events at bit 31 instead of bit 63, which reaches the masked arithmetic behind the carry and borrow inference. The wide vectors hit the most negative value, carry and borrow across the full width, and the case of a zero result from two negative addends.

// File: rtl/ccg_pkg.sv
package ccg_pkg;

  localparam int OP_W = 5;

  // Selector encoding; the values are part of the interface.
  typedef enum logic [OP_W-1:0] {
    OP_K0    = 5'd0,
    OP_K1    = 5'd1,
    OP_K2    = 5'd2,
    OP_K3    = 5'd3,
    OP_CMPS  = 5'd4,
    OP_CMPU  = 5'd5,
    OP_TSTZ  = 5'd6,
    OP_NZ    = 5'd7,
    OP_ADDS  = 5'd8,
    OP_SUBS  = 5'd9,
    OP_ADDL  = 5'd10,
    OP_ADDLC = 5'd11,
    OP_SUBL  = 5'd12,
    OP_SUBLB = 5'd13,
    OP_ABS   = 5'd14,
    OP_NABS  = 5'd15,
    OP_CPL   = 5'd16
  } ccg_op_e;

  // Ordering code: 0 equal/zero, 1 lower/negative, 2 higher/positive.
  function automatic logic [1:0] order_code(input logic is_eq, input logic is_lt);
    if (is_eq)      return 2'd0;
    else if (is_lt) return 2'd1;
    else            return 2'd2;
  endfunction

endpackage

// File: rtl/ccg_compare.sv
module ccg_compare
  import ccg_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] a_u,
  input  logic [DATA_W-1:0] b_u,
  input  logic              a_neg,
  input  logic              b_neg,
  input  logic [DATA_W-1:0] r_u,
  input  logic              r_neg,
  output logic [1:0]        cc
);

  logic same_ab;
  logic ult_ab;
  logic slt_ab;

  assign same_ab = (a_u == b_u);
  assign ult_ab  = (a_u < b_u);
  // Signs differ: the negative one is lower; otherwise magnitude order holds.
  assign slt_ab  = (a_neg != b_neg) ? a_neg : ult_ab;

  always_comb begin
    case (op)
      OP_CMPS: cc = order_code(same_ab, slt_ab);
      OP_CMPU: cc = order_code(same_ab, ult_ab);
      default: cc = order_code(r_u == '0, r_neg);
    endcase
  end

endmodule

// File: rtl/ccg_addsub.sv
module ccg_addsub
  import ccg_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] mask,
  input  logic [DATA_W-1:0] a_u,
  input  logic [DATA_W-1:0] b_u,
  input  logic [DATA_W-1:0] r_u,
  input  logic              a_neg,
  input  logic              b_neg,
  input  logic              r_neg,
  output logic [1:0]        cc
);

  logic r_nz;
  logic a_pos, b_pos, r_pos;
  logic add_ovf, sub_ovf;
  logic [DATA_W-1:0] b_plus_cin;
  logic [DATA_W-1:0] plain_diff;
  logic carry_plain, carry_cin;
  logic borrow_in, borrow_out;

  assign r_nz  = (r_u != '0);
  assign a_pos = !a_neg && (a_u != '0);
  assign b_pos = !b_neg && (b_u != '0);
  assign r_pos = !r_neg && r_nz;

  assign add_ovf = (a_pos && b_pos && r_neg) || (a_neg && b_neg && r_pos);
  assign sub_ovf = (a_pos && b_neg && r_neg) || (a_neg && b_pos && r_pos);

  // Carry inference: a wrapped sum lands below an addend.
  assign carry_plain = (r_u < a_u);
  assign b_plus_cin  = (r_u - a_u) & mask;
  assign carry_cin   = (b_plus_cin < b_u) || carry_plain;

  // Borrow-in inference: the result disagrees with the plain difference.
  assign plain_diff = (a_u - b_u) & mask;
  assign borrow_in  = (r_u != plain_diff);
  assign borrow_out = borrow_in ? (b_u >= a_u) : (b_u > a_u);

  always_comb begin
    case (op)
      OP_ADDS:  cc = add_ovf ? 2'd3 : order_code(!r_nz, r_neg);
      OP_SUBS:  cc = sub_ovf ? 2'd3 : order_code(!r_nz, r_neg);
      OP_ADDL:  cc = {carry_plain, r_nz};
      OP_ADDLC: cc = {carry_cin, r_nz};
      OP_SUBL:  cc = !r_nz ? 2'd2 : ((b_u > a_u) ? 2'd1 : 2'd3);
      default:  cc = {!borrow_out, r_nz};
    endcase
  end

endmodule

// File: rtl/ccg_unary.sv
module ccg_unary
  import ccg_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] r_u,
  input  logic              r_neg,
  input  logic [DATA_W-1:0] min_val,
  output logic [1:0]        cc
);

  logic r_nz;
  logic r_min;

  assign r_nz  = (r_u != '0);
  assign r_min = (r_u == min_val);

  always_comb begin
    case (op)
      OP_ABS:  cc = r_min ? 2'd3 : {1'b0, r_nz};
      OP_CPL:  cc = r_min ? 2'd3 : order_code(!r_nz, r_neg);
      default: cc = {1'b0, r_nz};
    endcase
  end

endmodule

// File: rtl/cc_gen.sv
module cc_gen
  import ccg_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic              wide_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic [DATA_W-1:0] res_i,
  output logic [1:0]        cc_o,
  output logic              illegal_o
);

  localparam int N_OPND = 3;
  localparam int HI_W   = DATA_W - NARROW_W;
  localparam logic [DATA_W-1:0] LOW_MASK = {{HI_W{1'b0}}, {NARROW_W{1'b1}}};
  localparam logic [DATA_W-1:0] WIDE_MIN = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] NARR_MIN = {{HI_W{1'b0}}, 1'b1, {(NARROW_W-1){1'b0}}};

  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] min_val;
  logic [DATA_W-1:0] raw  [N_OPND];
  logic [DATA_W-1:0] opu  [N_OPND];
  logic              oneg [N_OPND];

  assign mask    = wide_i ? {DATA_W{1'b1}} : LOW_MASK;
  assign min_val = wide_i ? WIDE_MIN : NARR_MIN;
  assign raw[0]  = opa_i;
  assign raw[1]  = opb_i;
  assign raw[2]  = res_i;

  // Per-operand width normalisation: zero-extended value plus sign bit.
  for (genvar g = 0; g < N_OPND; g++) begin : g_norm
    assign opu[g]  = raw[g] & mask;
    assign oneg[g] = wide_i ? raw[g][DATA_W-1] : raw[g][NARROW_W-1];
  end

  logic [1:0] cmp_cc, as_cc, un_cc;

  ccg_compare #(.DATA_W(DATA_W)) u_cmp (
    .op(op_i), .a_u(opu[0]), .b_u(opu[1]), .a_neg(oneg[0]), .b_neg(oneg[1]),
    .r_u(opu[2]), .r_neg(oneg[2]), .cc(cmp_cc)
  );

  ccg_addsub #(.DATA_W(DATA_W)) u_as (
    .op(op_i), .mask(mask), .a_u(opu[0]), .b_u(opu[1]), .r_u(opu[2]),
    .a_neg(oneg[0]), .b_neg(oneg[1]), .r_neg(oneg[2]), .cc(as_cc)
  );

  ccg_unary #(.DATA_W(DATA_W)) u_un (
    .op(op_i), .r_u(opu[2]), .r_neg(oneg[2]), .min_val(min_val), .cc(un_cc)
  );

  logic [1:0] cc_d;
  logic       ill_d;

  always_comb begin
    ill_d = 1'b0;
    case (op_i)
      OP_K0, OP_K1, OP_K2, OP_K3:                         cc_d = op_i[1:0];
      OP_CMPS, OP_CMPU, OP_TSTZ:                          cc_d = cmp_cc;
      OP_ADDS, OP_SUBS, OP_ADDL, OP_ADDLC, OP_SUBL, OP_SUBLB: cc_d = as_cc;
      OP_NZ, OP_ABS, OP_NABS, OP_CPL:                     cc_d = un_cc;
      default: begin
        cc_d  = 2'd0;
        ill_d = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cc_o      <= 2'd0;
      illegal_o <= 1'b0;
    end else begin
      cc_o      <= cc_d;
      illegal_o <= ill_d;
    end
  end

  // Checks on the registered outputs against the previous cycle's inputs.
  logic chk_res_zero, chk_ab_same, chk_res_min;
  assign chk_res_zero = wide_i ? (res_i == '0) : (res_i[NARROW_W-1:0] == '0);
  assign chk_ab_same  = wide_i ? (opa_i == opb_i)
                               : (opa_i[NARROW_W-1:0] == opb_i[NARROW_W-1:0]);
  assign chk_res_min  = wide_i ? (res_i == WIDE_MIN)
                               : (res_i[NARROW_W-1:0] == NARR_MIN[NARROW_W-1:0]);

  AST_RESET_CLEAR: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> (cc_o == 2'd0 && !illegal_o)); // R1
  AST_CONST_PASS: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && $past(op_i) < 5'd4) |-> (cc_o == $past(op_i[1:0]))); // R2
  AST_CMPU_EQUAL: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && $past(op_i) == OP_CMPU && $past(chk_ab_same)) |-> (cc_o == 2'd0)); // R3
  AST_TSTZ_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && $past(op_i) == OP_TSTZ && $past(chk_res_zero)) |-> (cc_o == 2'd0)); // R4
  AST_ADDS_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && $past(op_i) == OP_ADDS && $past(chk_res_zero)) |-> (cc_o == 2'd0)); // R5
  AST_SUBS_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && $past(op_i) == OP_SUBS && $past(chk_res_zero)) |-> (cc_o == 2'd0)); // R6
  AST_ADDL_NZ_BIT: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && ($past(op_i) == OP_ADDL || $past(op_i) == OP_ADDLC))
      |-> (cc_o[0] == !$past(chk_res_zero))); // R7
  AST_SUBL_NONZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && $past(op_i) == OP_SUBL) |-> (cc_o != 2'd0)); // R8
  AST_SUBLB_NZ_BIT: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && $past(op_i) == OP_SUBLB) |-> (cc_o[0] == !$past(chk_res_zero))); // R9
  AST_ABS_MIN: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && ($past(op_i) == OP_ABS || $past(op_i) == OP_CPL) && $past(chk_res_min))
      |-> (cc_o == 2'd3)); // R10
  AST_NABS_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && ($past(op_i) == OP_NABS || $past(op_i) == OP_NZ))
      |-> (cc_o == {1'b0, !$past(chk_res_zero)})); // R11
  AST_ILLEGAL_CODE: assert property (@(posedge clk_i) disable iff (rst_i)
    illegal_o |-> (cc_o == 2'd0)); // R13
  AST_ILLEGAL_FLAG: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i)) |-> (illegal_o == ($past(op_i) > 5'd16))); // R13

endmodule

// File: tb/cc_gen_tb.sv
`timescale 1ns/1ps
module cc_gen_tb;

  localparam int DW = 64;
  localparam logic [63:0] F64 = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] FE  = 64'hFFFF_FFFF_FFFF_FFFE;
  localparam logic [63:0] M64 = 64'h8000_0000_0000_0000;
  localparam logic [63:0] X64 = 64'h7FFF_FFFF_FFFF_FFFF;

  typedef struct packed {
    logic [4:0]  op;
    logic        wide;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] r;
    logic [1:0]  cc;
    logic        ill;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 50;
  localparam vec_t VECS [NV] = '{
    // R2 fixed codes
    '{5'd0, 1'b1, 64'd0, 64'd0, 64'd0, 2'd0, 1'b0, 4'd2},
    '{5'd1, 1'b1, F64, F64, F64, 2'd1, 1'b0, 4'd2},
    '{5'd2, 1'b1, 64'd0, 64'd0, 64'd0, 2'd2, 1'b0, 4'd2},
    '{5'd3, 1'b1, 64'd0, 64'd0, 64'd0, 2'd3, 1'b0, 4'd2},
    // R3 compares
    '{5'd4, 1'b1, F64, 64'd1, 64'd0, 2'd1, 1'b0, 4'd3},
    '{5'd4, 1'b1, 64'd5, 64'd5, 64'd0, 2'd0, 1'b0, 4'd3},
    '{5'd4, 1'b1, 64'd1, F64, 64'd0, 2'd2, 1'b0, 4'd3},
    '{5'd5, 1'b1, F64, 64'd1, 64'd0, 2'd2, 1'b0, 4'd3},
    '{5'd5, 1'b1, 64'd1, 64'd2, 64'd0, 2'd1, 1'b0, 4'd3},
    // R4 sign test
    '{5'd6, 1'b1, 64'd0, 64'd0, M64, 2'd1, 1'b0, 4'd4},
    '{5'd6, 1'b1, 64'd0, 64'd0, 64'd7, 2'd2, 1'b0, 4'd4},
    '{5'd6, 1'b1, F64, F64, 64'd0, 2'd0, 1'b0, 4'd4},
    // R5 signed add
    '{5'd8, 1'b1, X64, 64'd1, M64, 2'd3, 1'b0, 4'd5},
    '{5'd8, 1'b1, FE, 64'd1, F64, 2'd1, 1'b0, 4'd5},
    '{5'd8, 1'b1, M64, M64, 64'd0, 2'd0, 1'b0, 4'd5},
    '{5'd8, 1'b1, 64'd2, 64'd3, 64'd5, 2'd2, 1'b0, 4'd5},
    // R6 signed subtract
    '{5'd9, 1'b1, M64, 64'd1, X64, 2'd3, 1'b0, 4'd6},
    '{5'd9, 1'b1, 64'd5, 64'd3, 64'd2, 2'd2, 1'b0, 4'd6},
    '{5'd9, 1'b1, X64, F64, M64, 2'd3, 1'b0, 4'd6},
    // R7 logical add, plain and with carry-in
    '{5'd10, 1'b1, F64, 64'd1, 64'd0, 2'd2, 1'b0, 4'd7},
    '{5'd10, 1'b1, 64'd1, 64'd2, 64'd3, 2'd1, 1'b0, 4'd7},
    '{5'd10, 1'b1, 64'd0, 64'd0, 64'd0, 2'd0, 1'b0, 4'd7},
    '{5'd11, 1'b1, F64, 64'd0, 64'd0, 2'd2, 1'b0, 4'd7},
    '{5'd11, 1'b1, 64'd0, F64, 64'd0, 2'd2, 1'b0, 4'd7},
    '{5'd11, 1'b1, 64'd1, 64'd1, 64'd3, 2'd1, 1'b0, 4'd7},
    // R8 logical subtract
    '{5'd12, 1'b1, 64'd5, 64'd5, 64'd0, 2'd2, 1'b0, 4'd8},
    '{5'd12, 1'b1, 64'd3, 64'd5, FE, 2'd1, 1'b0, 4'd8},
    '{5'd12, 1'b1, 64'd5, 64'd3, 64'd2, 2'd3, 1'b0, 4'd8},
    // R9 subtract with inferred borrow
    '{5'd13, 1'b1, 64'd5, 64'd3, 64'd2, 2'd3, 1'b0, 4'd9},
    '{5'd13, 1'b1, 64'd5, 64'd5, F64, 2'd1, 1'b0, 4'd9},
    '{5'd13, 1'b1, 64'd3, 64'd5, FE, 2'd1, 1'b0, 4'd9},
    '{5'd13, 1'b1, 64'd5, 64'd4, 64'd0, 2'd2, 1'b0, 4'd9},
    // R10 absolute value and complement
    '{5'd14, 1'b1, 64'd0, 64'd0, M64, 2'd3, 1'b0, 4'd10},
    '{5'd14, 1'b1, 64'd0, 64'd0, 64'd9, 2'd1, 1'b0, 4'd10},
    '{5'd14, 1'b1, 64'd0, 64'd0, 64'd0, 2'd0, 1'b0, 4'd10},
    '{5'd16, 1'b1, 64'd0, 64'd0, M64, 2'd3, 1'b0, 4'd10},
    '{5'd16, 1'b1, 64'd0, 64'd0, F64, 2'd1, 1'b0, 4'd10},
    '{5'd16, 1'b1, 64'd0, 64'd0, 64'd4, 2'd2, 1'b0, 4'd10},
    // R11 negative absolute value and nonzero test
    '{5'd15, 1'b1, 64'd0, 64'd0, M64, 2'd1, 1'b0, 4'd11},
    '{5'd15, 1'b1, 64'd0, 64'd0, 64'd0, 2'd0, 1'b0, 4'd11},
    '{5'd7, 1'b1, 64'd0, 64'd0, 64'h100, 2'd1, 1'b0, 4'd11},
    // R12 narrow reading
    '{5'd4, 1'b0, 64'h0000_0001_8000_0000, 64'd0, 64'd0, 2'd1, 1'b0, 4'd12},
    '{5'd6, 1'b0, 64'd0, 64'd0, 64'hFFFF_FFFF_0000_0000, 2'd0, 1'b0, 4'd12},
    '{5'd14, 1'b0, 64'd0, 64'd0, 64'h0000_0000_8000_0000, 2'd3, 1'b0, 4'd12},
    '{5'd8, 1'b0, 64'h7FFF_FFFF, 64'd1, 64'h8000_0000, 2'd3, 1'b0, 4'd12},
    '{5'd10, 1'b0, 64'hFFFF_FFFF, 64'd1, 64'h1_0000_0000, 2'd2, 1'b0, 4'd12},
    '{5'd13, 1'b0, 64'd5, 64'd5, 64'hFFFF_FFFF, 2'd1, 1'b0, 4'd12},
    '{5'd5, 1'b0, 64'hFFFF_FFFF_0000_0001, 64'd2, 64'd0, 2'd1, 1'b0, 4'd12},
    // R13 undefined selectors
    '{5'd17, 1'b1, 64'd0, 64'd0, 64'd0, 2'd0, 1'b1, 4'd13},
    '{5'd31, 1'b1, F64, F64, F64, 2'd0, 1'b1, 4'd13}
  };

  logic          clk = 1'b0;
  logic          rst;
  logic [4:0]    op;
  logic          wide;
  logic [DW-1:0] opa, opb, res;
  logic [1:0]    cc;
  logic          ill;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  cc_gen u_dut (
    .clk_i(clk), .rst_i(rst), .op_i(op), .wide_i(wide),
    .opa_i(opa), .opb_i(opb), .res_i(res), .cc_o(cc), .illegal_o(ill)
  );

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic check(input logic [1:0] cc_exp, input logic ill_exp, input int req);
    checks++;
    if (cc !== cc_exp || ill !== ill_exp) begin
      fails++;
      $display("FAIL R%0d: cc=%0d illegal=%0b, expected cc=%0d illegal=%0b",
               req, cc, ill, cc_exp, ill_exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, cycles=%0d expected below 20000", cycles);
      finish_run();
    end
  end

  initial begin
    rst = 1'b1; op = 5'd3; wide = 1'b1; opa = '0; opb = '0; res = '0;
    repeat (3) @(negedge clk);
    check(2'd0, 1'b0, 1); // R1 reset state
    rst = 1'b0;

    // Vector walk: drive at a falling edge, the output registers at the next
    // rising edge, sample at the following falling edge.
    for (int i = 0; i < NV; i++) begin
      op = VECS[i].op; wide = VECS[i].wide;
      opa = VECS[i].a; opb = VECS[i].b; res = VECS[i].r;
      @(negedge clk);
      check(VECS[i].cc, VECS[i].ill, int'(VECS[i].req));
    end

    // R1: one-cycle latency, the code follows the previous cycle's selector
    op = 5'd2; @(negedge clk);
    op = 5'd1; check(2'd2, 1'b0, 1);
    @(negedge clk); check(2'd1, 1'b0, 1);

    // R1: reset in mid-run clears a pending illegal flag and code
    op = 5'd20; @(negedge clk); check(2'd0, 1'b1, 13);
    op = 5'd3; rst = 1'b1; @(negedge clk); check(2'd0, 1'b0, 1);
    rst = 1'b0; @(negedge clk); check(2'd3, 1'b0, 2);

    // R12: upper bits changed alone leave a narrow compare unchanged
    op = 5'd5; wide = 1'b0; opa = 64'hDEAD_BEEF_0000_0007; opb = 64'h1234_5678_0000_0007;
    @(negedge clk); check(2'd0, 1'b0, 12);
    wide = 1'b1; @(negedge clk); check(2'd2, 1'b0, 12);

    finish_run();
  end

endmodule